// File: doc/BRIEF.md
# Accumulator Round-to-High-Word Unit

This block takes a 40-bit multiply-accumulate value and rounds it to its 16-bit high word. The value has three fields: an 8-bit overflow field in bits 39:32, the high word in bits 31:16 and the low word in bits 15:0. Rounding adds half of one high-word LSB (0x8000) across all 40 bits. The carry runs into the overflow field, which wraps without saturating.

A per-transfer mode bit sets how an exact tie is handled. A tie is a low word of exactly 0x8000. With the mode bit at 0 the tie goes to the even high word: bit 16 of the sum is cleared. With the mode bit at 1 the tie always rounds up. Every other low word gives the same result in both modes.

Both data sides use valid/ready handshakes and one output register.
- An input transfer happens on a rising edge where `in_valid` and `in_ready` are both high.
- The rounded result appears on `out_acc` with `out_valid` high from the next cycle.
- `in_ready` is high when the output register is empty or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the output is held unchanged and no new input is taken.

Top module: `acc_rounder`

## Requirements
- R1: With `round_mode` = 0 and low word 0x8000, the high word is incremented when it is odd and kept when it is even (0x0000 stays 0x0000, 0x0001 becomes 0x0002, 0x0002 stays 0x0002).
- R2: With `round_mode` = 1 and low word 0x8000, the high word is always incremented (0x0000 becomes 0x0001, 0x0001 becomes 0x0002).
- R3: For any low word other than 0x8000, both modes give the same result. A low word above 0x8000 increments the high word, and a low word below 0x8000 leaves it unchanged.
- R4: A carry out of the high word increments the 8-bit overflow field (bits 39:32), and a carry out of bit 39 is dropped without saturation.
- R5: The output low word equals the input low word plus 0x8000, modulo 2^16.
- R6: A result is presented with `out_valid` high in the cycle after its input transfer is accepted.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_acc` holds its value.
- R8: After reset `out_valid` is low.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value and mode are valid |
| in_ready | output | 1 | Unit can accept an input this cycle |
| in_acc | input | 40 | Accumulator value: overflow[39:32], high[31:16], low[15:0] |
| round_mode | input | 1 | Tie mode: 0 = round half to even, 1 = round half up |
| out_valid | output | 1 | Rounded result is valid |
| out_ready | input | 1 | Downstream accepts the result this cycle |
| out_acc | output | 40 | Rounded 40-bit value |

## Verification
A wrong tie decision shows as a high word that is off by one LSB. This shows on the first output after a 0x8000 low word, so the vector table pairs each tie with both an even and an odd high word in both modes. A broken carry chain shows as an overflow field that is stale or saturated, and this is exposed by the inputs at 0xFF_FFFF_8000 and 0x7F_FFFF_C000. A faulty output register shows under back-pressure within one cycle: either the held result changes or `in_ready` rises while a result is still stalled.

// File: rtl/acc_round_pkg.sv
package acc_round_pkg;
  typedef enum logic {
    TIE_TO_EVEN = 1'b0,
    TIE_UP      = 1'b1
  } tie_mode_e;
endpackage

// File: rtl/round_core.sv
module round_core
  import acc_round_pkg::*;
#(
  parameter int OVF_W = 8,
  parameter int HI_W  = 16,
  parameter int LO_W  = 16
) (
  input  logic [OVF_W+HI_W+LO_W-1:0] acc_i,
  input  tie_mode_e                  mode_i,
  output logic [OVF_W+HI_W+LO_W-1:0] acc_o
);
  localparam int ACC_W = OVF_W + HI_W + LO_W;
  localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (LO_W - 1);
  localparam logic [LO_W-1:0]  TIE_LO   = LO_W'(1) << (LO_W - 1);

  logic [ACC_W-1:0] biased_sum;
  logic             is_tie;

  // add half an LSB of the high word; carry wraps out of the top bit
  assign biased_sum = acc_i + HALF_LSB;
  assign is_tie     = (acc_i[LO_W-1:0] == TIE_LO);

  always_comb begin
    acc_o = biased_sum;
    if (is_tie && (mode_i == TIE_TO_EVEN)) begin
      acc_o[LO_W] = 1'b0;
    end
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end

  // R7: a stalled result keeps its slot and value
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  // R6: an accepted input is visible on the next cycle
  assert_accept_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (dn_valid && dn_data == $past(up_data)));
endmodule

// File: rtl/acc_rounder.sv
module acc_rounder
  import acc_round_pkg::*;
#(
  parameter int OVF_W = 8,
  parameter int HI_W  = 16,
  parameter int LO_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [OVF_W+HI_W+LO_W-1:0]  in_acc,
  input  logic                        round_mode,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [OVF_W+HI_W+LO_W-1:0]  out_acc
);
  localparam int ACC_W = OVF_W + HI_W + LO_W;
  localparam logic [LO_W-1:0] TIE_LO = LO_W'(1) << (LO_W - 1);

  logic [ACC_W-1:0] rounded;
  tie_mode_e        mode_e;

  assign mode_e = tie_mode_e'(round_mode);

  round_core #(.OVF_W(OVF_W), .HI_W(HI_W), .LO_W(LO_W)) u_core (
    .acc_i  (in_acc),
    .mode_i (mode_e),
    .acc_o  (rounded)
  );

  out_stage #(.W(ACC_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (rounded),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_acc)
  );

  logic take;
  assign take = in_valid && in_ready;

  // R2: tie in round-up mode always bumps the high word
  assert_tie_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && round_mode && in_acc[LO_W-1:0] == TIE_LO) |=>
      (out_acc[ACC_W-1:LO_W] == $past(in_acc[ACC_W-1:LO_W]) + 1'b1));

  // R1: tie in even mode lands on an even high word
  assert_tie_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !round_mode && in_acc[LO_W-1:0] == TIE_LO) |=> (out_acc[LO_W] == 1'b0));

  // R3: below half never changes the upper fields
  assert_below_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_acc[LO_W-1:0] < TIE_LO) |=>
      (out_acc[ACC_W-1:LO_W] == $past(in_acc[ACC_W-1:LO_W])));
endmodule

// File: tb/acc_rounder_tb.sv
module acc_rounder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [39:0] in_acc = '0;
  logic        round_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [39:0] out_acc;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  acc_rounder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .round_mode(round_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_acc(out_acc)
  );

  // {mode, input, expected}
  localparam int NV = 13;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 40'h00_0000_8000, 40'h00_0000_0000},  // R1 even stays
    {1'b0, 40'h00_0001_8000, 40'h00_0002_0000},  // R1 odd up
    {1'b0, 40'h00_0002_8000, 40'h00_0002_0000},  // R1 even stays
    {1'b1, 40'h00_0000_8000, 40'h00_0001_0000},  // R2
    {1'b1, 40'h00_0001_8000, 40'h00_0002_0000},  // R2
    {1'b0, 40'h00_0000_8001, 40'h00_0001_0001},  // R3
    {1'b1, 40'h00_0000_8001, 40'h00_0001_0001},  // R3
    {1'b0, 40'h00_0001_7FFF, 40'h00_0001_FFFF},  // R3
    {1'b1, 40'h00_0001_7FFF, 40'h00_0001_FFFF},  // R3
    {1'b0, 40'h00_FFFF_8000, 40'h01_0000_0000},  // R4 carry into overflow
    {1'b1, 40'hFF_FFFF_8000, 40'h00_0000_0000},  // R4 wrap
    {1'b0, 40'h7F_FFFF_C000, 40'h80_0000_4000},  // R4 no saturation
    {1'b1, 40'h12_3456_0000, 40'h12_3456_8000}   // R5 low word
  };

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic m, input logic [39:0] v);
    @(negedge clk);
    in_valid = 1'b1; round_mode = m; in_acc = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset valid", 40'(out_valid), 40'd0);
    chk(in_ready == 1'b1, "R9 idle ready", 40'(in_ready), 40'd1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][80], VEC[i][79:40]);
      chk(out_valid == 1'b1, "R6 valid after accept", 40'(out_valid), 40'd1);
      chk(out_acc == VEC[i][39:0], $sformatf("R1-5 vector %0d", i), out_acc, VEC[i][39:0]);
    end

    // back-pressure: R7 and R9
    @(negedge clk);
    out_ready = 1'b0;
    send(1'b1, 40'h00_0000_8000);
    chk(in_ready == 1'b0, "R9 stalled not ready", 40'(in_ready), 40'd0);
    in_valid = 1'b1; round_mode = 1'b0; in_acc = 40'h00_0003_8001;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R7 valid held", 40'(out_valid), 40'd1);
    chk(out_acc == 40'h00_0001_0000, "R7 data held", out_acc, 40'h00_0001_0000);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R9 drain ready", 40'(in_ready), 40'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_acc == 40'h00_0004_0001, "R6 next after drain", out_acc, 40'h00_0004_0001);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 empty after drain", 40'(out_valid), 40'd0);

    // reset mid-stream clears valid
    out_ready = 1'b0;
    send(1'b0, 40'h00_0010_0000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R8 reset clears", 40'(out_valid), 40'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule